// File: doc/BRIEF.md
# Banked GPIO Controller with Interrupt Detection

This block is a memory-mapped general-purpose I/O controller for up to 64 pins (41 by default). Every per-pin setting is one bit in a 32-bit register. Pins 0..31 sit in the first register of a feature and pins 32..63 in the second register, four bytes higher. The settings are:

- direction (output enable)
- drive value
- interrupt type (level or edge)
- interrupt polarity
- four independent interrupt-enable sets
- a latched interrupt status with write-one-to-clear

Pad inputs pass through a two-flop synchroniser, after which each pin is checked for its configured level or edge condition. The detected condition sets the pin's status bit. Each of the four interrupt request lines is the registered OR of status masked by one enable set, so four consumers can watch different groups of pins.

Software uses a single-cycle bus. A write takes effect on the clock edge where `bus_wr` is high. A read is combinational from `bus_addr`.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: Pin n of a feature is bit n mod 32 of the register at the feature's base plus (n/32)*4. The bases are:
  - 0x00 output enable
  - 0x08 drive value
  - 0x18, 0x20, 0x28, 0x30 interrupt-enable sets 0..3
  - 0x38 polarity
  - 0x40 type
  - 0x48 status
- R2: Register bits for pins at or above NUM_PINS read as zero and ignore writes. Unmapped or misaligned addresses (such as 0x10, 0x14, 0x50, 0x02) read as zero.
- R3: `pad_oe[n]` equals the output-enable bit of pin n on the cycle after the write. `pad_out[n]` equals the drive bit when output enable is 1, and is 0 otherwise.
- R4: A pad input change at a clock edge reaches the status register on the third rising edge, because it passes two synchroniser flops before detection.
- R5: Type bit 0 selects level detection. Polarity bit 0 makes a high level active and polarity bit 1 makes a low level active. The status bit is set again on every cycle the active level persists, even straight after a clear.
- R6: Type bit 1 selects edge detection. Polarity 0 selects a rising edge and polarity 1 a falling edge. An edge sets the status bit, and the bit stays set after the pad returns.
- R7: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. A detection in the same cycle as the clear wins.
- R8: `irq_out[k]` is high one cycle after any pin has both its status bit and its set-k enable bit high.
- R9: Synchronous reset zeroes every register, so all pins are inputs, `pad_out` and `irq_out` are 0, and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pad_in | input | NUM_PINS | Asynchronous pad input levels |
| pad_out | output | NUM_PINS | Pad output values |
| pad_oe | output | NUM_PINS | Pad output enables |
| irq_out | output | 4 | Interrupt requests, one per enable set |

## Verification
The timing of each output, counted from the edge that captures a stimulus, is:

| Output | Due |
|---|---|
| Register readback after a write | Just after the capturing edge |
| `pad_oe`, `pad_out` | Just after the capturing edge |
| Status, after a pad change | Three edges later |
| Interrupt line | One edge after status |

The bench holds a behavioural model that advances on the same edge as the design. It compares all outputs, plus the read data for the current address, shortly after every rising edge. Each expected value therefore carries exactly the latency above. Holding the address on the status register while a pad toggles makes the per-cycle comparison verify the synchroniser depth directly.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int BUS_AW     = 8;
    localparam int WORD_W     = 32;
    localparam int MAX_PINS   = 2 * WORD_W;
    localparam int N_ENSETS   = 4;
    localparam int N_CFG      = 8;

    // Feature index; numeric value also indexes the configuration array.
    typedef enum logic [3:0] {
        FEAT_OE   = 4'd0,
        FEAT_DRV  = 4'd1,
        FEAT_EN0  = 4'd2,
        FEAT_EN1  = 4'd3,
        FEAT_EN2  = 4'd4,
        FEAT_EN3  = 4'd5,
        FEAT_POL  = 4'd6,
        FEAT_TYPE = 4'd7,
        FEAT_STAT = 4'd8
    } feat_e;

    typedef struct packed {
        logic  hit;
        logic  bank;
        feat_e feat;
    } dec_t;

    function automatic dec_t decode(input logic [BUS_AW-1:0] a);
        dec_t d;
        d.hit  = 1'b0;
        d.bank = a[2];
        d.feat = FEAT_OE;
        if (a[1:0] == 2'b00) begin
            d.hit = 1'b1;
            case (a[7:3])
                5'h00:   d.feat = FEAT_OE;
                5'h01:   d.feat = FEAT_DRV;
                5'h03:   d.feat = FEAT_EN0;
                5'h04:   d.feat = FEAT_EN1;
                5'h05:   d.feat = FEAT_EN2;
                5'h06:   d.feat = FEAT_EN3;
                5'h07:   d.feat = FEAT_POL;
                5'h08:   d.feat = FEAT_TYPE;
                5'h09:   d.feat = FEAT_STAT;
                default: d.hit  = 1'b0;
            endcase
        end
        return d;
    endfunction

    function automatic logic [MAX_PINS-1:0] bank_mask(input logic bank);
        return bank ? {{WORD_W{1'b1}}, {WORD_W{1'b0}}}
                    : {{WORD_W{1'b0}}, {WORD_W{1'b1}}};
    endfunction

    // Replace one 32-bit bank of a wide vector with new data.
    function automatic logic [MAX_PINS-1:0] bank_merge(input logic [MAX_PINS-1:0] old,
                                                       input logic [WORD_W-1:0]   wd,
                                                       input logic                bank);
        logic [MAX_PINS-1:0] m;
        m = bank_mask(bank);
        return (old & ~m) | ({wd, wd} & m);
    endfunction

    function automatic logic [WORD_W-1:0] bank_pick(input logic [MAX_PINS-1:0] v,
                                                    input logic                bank);
        return bank ? v[MAX_PINS-1:WORD_W] : v[WORD_W-1:0];
    endfunction

endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 41
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                wr_en,
    input  dec_t                                dec,
    input  logic [WORD_W-1:0]                   wdata,
    output logic [N_CFG-1:0][NUM_PINS-1:0]      cfg_q
);

    genvar gi;
    generate
        for (gi = 0; gi < N_CFG; gi++) begin : g_cfg
            logic sel;
            assign sel = wr_en && dec.hit && (dec.feat == feat_e'(gi));

            always_ff @(posedge clk) begin
                if (rst) begin
                    cfg_q[gi] <= '0;
                end else if (sel) begin
                    // Truncation drops bits of pins beyond NUM_PINS.
                    cfg_q[gi] <= NUM_PINS'(bank_merge(MAX_PINS'(cfg_q[gi]), wdata, dec.bank));
                end
            end
        end
    endgenerate

endmodule

// File: rtl/gpio_event_detect.sv
module gpio_event_detect #(
    parameter int NUM_PINS = 41
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pad_in,
    input  logic [NUM_PINS-1:0] pol,
    input  logic [NUM_PINS-1:0] edge_mode,
    input  logic [NUM_PINS-1:0] clr,
    output logic [NUM_PINS-1:0] stat_q
);

    logic [NUM_PINS-1:0] meta_q;
    logic [NUM_PINS-1:0] sync_q;
    logic [NUM_PINS-1:0] prev_q;
    logic [NUM_PINS-1:0] lvl_hit;
    logic [NUM_PINS-1:0] rise;
    logic [NUM_PINS-1:0] fall;
    logic [NUM_PINS-1:0] edg_hit;
    logic [NUM_PINS-1:0] stat_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pad_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    always_comb begin
        rise    = sync_q & ~prev_q;
        fall    = ~sync_q & prev_q;
        lvl_hit = ~edge_mode & (sync_q ^ pol);
        edg_hit = edge_mode & ((rise & ~pol) | (fall & pol));
        // New detections take priority over a simultaneous clear.
        stat_d  = (stat_q & ~clr) | lvl_hit | edg_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= stat_d;
    end

endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 41
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [NUM_PINS-1:0]                 stat,
    input  logic [N_ENSETS-1:0][NUM_PINS-1:0]   en,
    output logic [N_ENSETS-1:0]                 irq_q
);

    genvar gk;
    generate
        for (gk = 0; gk < N_ENSETS; gk++) begin : g_line
            always_ff @(posedge clk) begin
                if (rst) irq_q[gk] <= 1'b0;
                else     irq_q[gk] <= |(stat & en[gk]);
            end
        end
    endgenerate

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 41
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic [7:0]            bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [NUM_PINS-1:0]   pad_in,
    output logic [NUM_PINS-1:0]   pad_out,
    output logic [NUM_PINS-1:0]   pad_oe,
    output logic [3:0]            irq_out
);

    dec_t                                dec;
    logic [N_CFG-1:0][NUM_PINS-1:0]      cfg_q;
    logic [N_ENSETS-1:0][NUM_PINS-1:0]   en_q;
    logic [NUM_PINS-1:0]                 stat_q;
    logic [NUM_PINS-1:0]                 clr_vec;
    logic [3:0]                          fidx;
    logic [MAX_PINS-1:0]                 rd_src;

    assign dec  = decode(bus_addr);
    assign fidx = dec.feat;

    gpio_cfg_regs #(.NUM_PINS(NUM_PINS)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr_en (bus_wr),
        .dec   (dec),
        .wdata (bus_wdata),
        .cfg_q (cfg_q)
    );

    genvar gk;
    generate
        for (gk = 0; gk < N_ENSETS; gk++) begin : g_en
            assign en_q[gk] = cfg_q[int'(FEAT_EN0) + gk];
        end
    endgenerate

    // Write-one-to-clear vector for the addressed status bank.
    always_comb begin
        clr_vec = '0;
        if (bus_wr && dec.hit && dec.feat == FEAT_STAT)
            clr_vec = NUM_PINS'({bus_wdata, bus_wdata} & bank_mask(dec.bank));
    end

    gpio_event_detect #(.NUM_PINS(NUM_PINS)) u_det (
        .clk       (clk),
        .rst       (rst),
        .pad_in    (pad_in),
        .pol       (cfg_q[FEAT_POL]),
        .edge_mode (cfg_q[FEAT_TYPE]),
        .clr       (clr_vec),
        .stat_q    (stat_q)
    );

    gpio_irq_merge #(.NUM_PINS(NUM_PINS)) u_irq (
        .clk   (clk),
        .rst   (rst),
        .stat  (stat_q),
        .en    (en_q),
        .irq_q (irq_out)
    );

    always_comb begin
        rd_src    = '0;
        bus_rdata = '0;
        if (dec.hit) begin
            if (fidx == 4'(FEAT_STAT)) rd_src = MAX_PINS'(stat_q);
            else                       rd_src = MAX_PINS'(cfg_q[fidx[2:0]]);
            bus_rdata = bank_pick(rd_src, dec.bank);
        end
    end

    assign pad_oe  = cfg_q[FEAT_OE];
    assign pad_out = cfg_q[FEAT_DRV] & cfg_q[FEAT_OE];

endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
    parameter int NUM_PINS = 41
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     bus_wr,
    input logic [7:0]               bus_addr,
    input logic [31:0]              bus_wdata,
    input logic [31:0]              bus_rdata,
    input logic [NUM_PINS-1:0]      pad_oe,
    input logic [3:0]               irq_out,
    input logic [NUM_PINS-1:0]      stat_q,
    input logic [NUM_PINS-1:0]      clr_vec,
    input logic [3:0][NUM_PINS-1:0] en_all
);

    localparam int          LOW_W    = (NUM_PINS < 32) ? NUM_PINS : 32;
    localparam logic [31:0] LOW_MASK = (LOW_W == 32) ? 32'hFFFF_FFFF : ((32'h1 << LOW_W) - 32'h1);

    a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 8'h10 || bus_addr == 8'h50) |-> bus_rdata == 32'h0);

    a_r3_oe_follows_write: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 8'h00) |=> 32'(pad_oe[LOW_W-1:0]) == ($past(bus_wdata) & LOW_MASK));

    a_r7_status_sticky: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (($past(stat_q) & ~$past(clr_vec)) & ~stat_q) == '0);

    genvar gk;
    generate
        for (gk = 0; gk < 4; gk++) begin : g_irq_chk
            a_r8_irq_line: assert property (@(posedge clk) disable iff (rst)
                !rst |=> irq_out[gk] == |($past(stat_q) & $past(en_all[gk])));
        end
    endgenerate

    a_r9_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (pad_oe == '0 && irq_out == 4'h0 && stat_q == '0));

endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_oe    (pad_oe),
    .irq_out   (irq_out),
    .stat_q    (stat_q),
    .clr_vec   (clr_vec),
    .en_all    (en_q)
);

// File: tb/gpio_bank_ctrl_tb.sv
module gpio_bank_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NP         = 41;
    localparam int WATCHDOG   = 20000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = 8'h00;
    logic [31:0]   bus_wdata = 32'h0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;
    logic [3:0]    irq_out;

    int    n_cmp  = 0;
    int    n_bad  = 0;
    int    cycles = 0;
    bit    done   = 0;
    string phase  = "R9";

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_bank_ctrl #(.NUM_PINS(NP)) u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq_out(irq_out)
    );

    // ---------------- reference model ----------------
    // feature slots: 0 oe, 1 drive, 2..5 enable sets, 6 polarity, 7 type, 8 status
    logic [63:0] m_reg [9];
    logic [63:0] m_s1, m_s2, m_prev, m_nst;
    logic [3:0]  m_irq, m_nirq;
    logic        m_hit;

    function automatic int base_of(input int f);
        case (f)
            0: return 'h00;  1: return 'h08;  2: return 'h18;  3: return 'h20;
            4: return 'h28;  5: return 'h30;  6: return 'h38;  7: return 'h40;
            default: return 'h48;
        endcase
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        logic [31:0] r = 32'h0;
        for (int f = 0; f < 9; f++)
            for (int n = 0; n < NP; n++)
                if (int'(a) == base_of(f) + (n / 32) * 4) r[n % 32] = m_reg[f][n];
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int f = 0; f < 9; f++) m_reg[f] = '0;
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_irq = '0;
        end else begin
            for (int k = 0; k < 4; k++) m_nirq[k] = |(m_reg[8] & m_reg[2+k]);
            m_nst = m_reg[8];
            for (int n = 0; n < NP; n++) begin
                if (bus_wr && int'(bus_addr) == base_of(8) + (n / 32) * 4 && bus_wdata[n % 32])
                    m_nst[n] = 1'b0;
                if (!m_reg[7][n]) m_hit = m_s2[n] ^ m_reg[6][n];
                else if (m_reg[6][n]) m_hit = !m_s2[n] && m_prev[n];
                else m_hit = m_s2[n] && !m_prev[n];
                if (m_hit) m_nst[n] = 1'b1;
            end
            if (bus_wr)
                for (int f = 0; f < 8; f++)
                    for (int n = 0; n < NP; n++)
                        if (int'(bus_addr) == base_of(f) + (n / 32) * 4)
                            m_reg[f][n] = bus_wdata[n % 32];
            m_prev = m_s2; m_s2 = m_s1; m_s1 = 64'(pad_in);
            m_reg[8] = m_nst; m_irq = m_nirq;
        end
    end

    task automatic cmp(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s @%0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    // Compare shortly after every rising edge.
    always @(posedge clk) begin
        #1;
        if (!done) begin
            cmp("R3 pad_oe",  64'(pad_oe),    64'(m_reg[0][NP-1:0]));
            cmp("R3 pad_out", 64'(pad_out),   64'(m_reg[1][NP-1:0] & m_reg[0][NP-1:0]));
            cmp("R8 irq_out", 64'(irq_out),   64'(m_irq));
            cmp(phase,        64'(bus_rdata), 64'(m_read(bus_addr)));
        end
    end

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    // ---------------- stimulus ----------------
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a);
        @(negedge clk);
        bus_addr = a;
        @(negedge clk);
    endtask

    initial begin
        // R9: reset values, every mapped register reads zero
        idle(3);
        rst = 1'b0;
        for (int a = 0; a <= 'h4C; a += 4) rd(8'(a));

        // R1 / R2: bank layout, readback, masked upper pins, unmapped holes
        phase = "R1";
        wr(8'h00, 32'hA5A5_0F0F);
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h08, 32'h1234_5678);
        wr(8'h0C, 32'hFFFF_FE01);
        rd(8'h00); rd(8'h04); rd(8'h08); rd(8'h0C);
        phase = "R2";
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h10); rd(8'h14); rd(8'h50); rd(8'h02); rd(8'h04);

        // R3: direction back to input gates drive
        phase = "R3";
        wr(8'h00, 32'h0000_00FF);
        wr(8'h04, 32'h0);
        idle(2);

        // R4 / R5: level-high on pin 3 with latency visible on the status read
        phase = "R4";
        wr(8'h18, 32'h0000_0008);
        rd(8'h48);
        @(negedge clk); pad_in[3] = 1'b1;
        idle(5);
        phase = "R5";
        wr(8'h48, 32'h0000_0008);
        idle(2);
        @(negedge clk); pad_in[3] = 1'b0;
        idle(4);
        wr(8'h48, 32'h0000_0008);
        idle(3);
        // level-low on pin 5: polarity 1
        wr(8'h38, 32'h0000_0020);
        wr(8'h20, 32'h0000_0020);
        idle(4);
        @(negedge clk); pad_in[5] = 1'b1;
        idle(4);
        wr(8'h48, 32'h0000_0020);
        idle(3);

        // R6: rising edge pin 40, falling edge pin 33 (bank 1)
        phase = "R6";
        wr(8'h44, 32'h0000_0102);
        wr(8'h3C, 32'h0000_0002);
        wr(8'h2C, 32'h0000_0100);
        wr(8'h34, 32'h0000_0002);
        wr(8'h4C, 32'hFFFF_FFFF);
        rd(8'h4C);
        @(negedge clk); pad_in[40] = 1'b1; pad_in[33] = 1'b1;
        idle(5);
        @(negedge clk); pad_in[40] = 1'b0;
        idle(5);
        @(negedge clk); pad_in[33] = 1'b0;
        idle(5);

        // R7: writing 0 keeps, writing 1 clears
        phase = "R7";
        wr(8'h4C, 32'h0000_0000);
        rd(8'h4C);
        wr(8'h4C, 32'h0000_0100);
        rd(8'h4C);
        wr(8'h4C, 32'h0000_0002);
        rd(8'h4C);

        // R8: several enable sets sharing one pin
        phase = "R8";
        wr(8'h24, 32'h0000_0100);
        wr(8'h28, 32'h0000_0008);
        @(negedge clk); pad_in[40] = 1'b1; pad_in[3] = 1'b1;
        idle(6);
        wr(8'h4C, 32'h0000_0100);
        @(negedge clk); pad_in[3] = 1'b0;
        idle(4);
        wr(8'h48, 32'hFFFF_FFFF);
        idle(4);

        // R9 again: reset mid-run
        phase = "R9";
        @(negedge clk); rst = 1'b1;
        idle(2);
        @(negedge clk); rst = 1'b0; pad_in = '0;
        for (int a = 0; a <= 'h4C; a += 4) rd(8'(a));

        finish_run();
    end

endmodule